// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences one logical DMA channel. A transfer is a block of frames, and every frame is a run of elements. The sequencer counts position within the block and issues one transfer strobe per element to an external datapath. It then waits for the datapath's completion handshake before it moves on. Address generation, bus protocol and arbitration sit outside; the strobe carries the position flags and the channel's priority bit so that those neighbours can act on them.

Each hardware request grants a chosen amount of work: a single element, a whole frame, or the whole block. A select value of zero disables request gating, so the channel runs freely once it is enabled. At the end of a block the channel either stops or reloads, depending on its auto-reload policy. Six event kinds are latched into sticky status bits, and a mask folds them into one interrupt line.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset, `xfer_go`, `status` and `irq` are all zero.
- R2: With `frame_sync` and `block_sync` both low and `sync_sel` nonzero, each pulse on the selected request line yields exactly one `xfer_go` strobe. `xfer_go` is never high in two consecutive cycles.
- R3: With `frame_sync` high, one request yields one strobe for every element of the current frame.
- R4: With `frame_sync` low and `block_sync` high, one request yields strobes for every remaining element of the block. `frame_sync` takes precedence when both are high.
- R5: A `sync_sel` of 0 runs the whole block after enable with no request. A value k in 1..31 selects `req_in[k-1]`.
- R6: While `xfer_go` is high, `last_elem` and `last_frame` mark the final element of the frame and the final frame of the block. An element or frame count of 0 counts as 1.
- R7: `status[0]` is set when the number of completed elements in a frame reaches floor(elements/2). This event never occurs for one-element frames. `status[1]` is set when a frame completes.
- R8: `status[2]` is set on the strobe of the first element of the last frame. `status[3]` is set when the last element of the block completes.
- R9: `status[4]` is set when the selected request line pulses while a strobe or an element completion is pending.
- R10: If `elem_done` stays low for `to_limit` consecutive cycles while a completion is awaited, `status[5]` is set and the block is aborted, with no further strobes until re-enable. A `to_limit` of 0 disables the timeout.
- R11: With `auto_init` low, the channel stops after the block. Requests are then ignored until `ch_en` goes low and high again.
- R12: With `auto_init` high, the channel restarts after the block if `repeat_en` or `end_prog` is high. If both are low, it waits until `end_prog` rises.
- R13: Status bits appear one cycle after their event and are sticky. A `stat_clr` pulse clears them, but an event in the same cycle wins. `irq` is the OR of `status & irq_mask`.
- R14: `xfer_hi` equals `xfer_go` AND `hi_prio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | 1 | Channel enable; low returns to idle |
| elem_cnt | input | CNT_W | Elements per frame |
| frame_cnt | input | CNT_W | Frames per block |
| frame_sync | input | 1 | One request grants a frame |
| block_sync | input | 1 | One request grants the block |
| sync_sel | input | SEL_W | Request line select, 0 = free running |
| auto_init | input | 1 | Reload after block |
| repeat_en | input | 1 | Reload unconditionally when auto_init |
| end_prog | input | 1 | Reload permit when auto_init |
| hi_prio | input | 1 | Channel priority bit |
| irq_mask | input | 6 | Per-event interrupt enable |
| to_limit | input | TO_W | Timeout in cycles, 0 = off |
| req_in | input | NREQ | Hardware request lines |
| elem_done | input | 1 | Element completion handshake |
| stat_clr | input | 1 | Clear pulse for status |
| xfer_go | output | 1 | Element transfer strobe |
| xfer_hi | output | 1 | Strobe carries high priority |
| last_elem | output | 1 | Strobe is last element of frame |
| last_frame | output | 1 | Strobe is in last frame |
| status | output | 6 | Sticky event bits |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong element or frame index shows up at the very next strobe. It appears as a misplaced `last_elem` or `last_frame` flag, and one cycle later as a half-frame, frame or block event in the wrong position. A wrong controller state or grant shows as an extra or missing `xfer_go` within a few cycles of a handshake, or as a strobe that should have been suppressed. Stuck or lost status bits are visible on `status` and `irq` one cycle after the event that should have set them. A reference model compared every cycle catches each of these within a cycle or two of the divergence.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_WREQ, ST_ISSUE, ST_WDONE, ST_HOLD, ST_DONE
   } seq_state_t;

   typedef enum logic [1:0] {
      GR_ELEM, GR_FRAME, GR_BLOCK
   } grant_t;

   localparam int EV_HALF     = 0;
   localparam int EV_FRAME    = 1;
   localparam int EV_LAST_FRM = 2;
   localparam int EV_BLOCK    = 3;
   localparam int EV_DROP     = 4;
   localparam int EV_TOUT     = 5;
   localparam int EV_NUM      = 6;

endpackage

// File: rtl/dma_req_pick.sv
module dma_req_pick #(
   parameter int NREQ  = 31,
   parameter int SEL_W = 5
) (
   input  logic [NREQ-1:0]  req_in,
   input  logic [SEL_W-1:0] sel,
   output logic             hit,
   output logic             unsync
);

   generate
      if (NREQ + 1 > (1 << SEL_W)) begin : g_bad_sel
         $error("dma_req_pick: SEL_W too narrow for NREQ lines");
      end
   endgenerate

   logic [NREQ-1:0] match;

   for (genvar k = 0; k < NREQ; k++) begin : g_line
      assign match[k] = req_in[k] && (sel == SEL_W'(k + 1));
   end

   assign hit    = |match;
   assign unsync = (sel == '0);

endmodule

// File: rtl/dma_pos_cnt.sv
module dma_pos_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             step,
   input  logic [CNT_W-1:0] elem_cnt,
   input  logic [CNT_W-1:0] frame_cnt,
   output logic             first_elem,
   output logic             last_elem,
   output logic             last_frame,
   output logic             ev_half,
   output logic             ev_frame,
   output logic             ev_block
);

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("dma_pos_cnt: CNT_W must be at least 2");
      end
   endgenerate

   localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
   localparam logic [CNT_W:0]   ONEX = (CNT_W+1)'(1);

   logic [CNT_W-1:0] ne, nf, e_q, f_q;
   logic [CNT_W:0]   done_cnt, half_mark;

   assign ne = (elem_cnt  == '0) ? ONE : elem_cnt;
   assign nf = (frame_cnt == '0) ? ONE : frame_cnt;

   assign first_elem = (e_q == '0);
   assign last_elem  = (e_q == ne - ONE);
   assign last_frame = (f_q == nf - ONE);

   assign done_cnt  = {1'b0, e_q} + ONEX;
   assign half_mark = {1'b0, (ne >> 1)};

   assign ev_half  = step && (ne != ONE) && (done_cnt == half_mark);
   assign ev_frame = step && last_elem;
   assign ev_block = ev_frame && last_frame;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_q <= '0;
         f_q <= '0;
      end else if (start) begin
         e_q <= '0;
         f_q <= '0;
      end else if (step) begin
         if (last_elem) begin
            e_q <= '0;
            f_q <= last_frame ? '0 : f_q + ONE;
         end else begin
            e_q <= e_q + ONE;
         end
      end
   end

   // R7
   half_frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_half && ev_frame));

   // R8
   block_wraps_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_block |=> (first_elem && f_q == '0));

endmodule

// File: rtl/dma_evt_stat.sv
module dma_evt_stat #(
   parameter int NEV = 6
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] set,
   input  logic           clr,
   input  logic [NEV-1:0] mask,
   output logic [NEV-1:0] status,
   output logic           irq
);

   for (genvar i = 0; i < NEV; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      status[i] <= 1'b0;
         else if (set[i]) status[i] <= 1'b1;
         else if (clr)    status[i] <= 1'b0;
      end
   end

   assign irq = |(status & mask);

   // R13
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
   import dma_seq_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int NREQ  = 31,
   parameter int SEL_W = 5,
   parameter int TO_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ch_en,
   input  logic [CNT_W-1:0]  elem_cnt,
   input  logic [CNT_W-1:0]  frame_cnt,
   input  logic              frame_sync,
   input  logic              block_sync,
   input  logic [SEL_W-1:0]  sync_sel,
   input  logic              auto_init,
   input  logic              repeat_en,
   input  logic              end_prog,
   input  logic              hi_prio,
   input  logic [EV_NUM-1:0] irq_mask,
   input  logic [TO_W-1:0]   to_limit,
   input  logic [NREQ-1:0]   req_in,
   input  logic              elem_done,
   input  logic              stat_clr,
   output logic              xfer_go,
   output logic              xfer_hi,
   output logic              last_elem,
   output logic              last_frame,
   output logic [EV_NUM-1:0] status,
   output logic              irq
);

   generate
      if (TO_W < 1) begin : g_bad_to
         $error("dma_chan_seq: TO_W must be positive");
      end
   endgenerate

   seq_state_t st_q, st_d;
   grant_t     grant_q, grant_d;
   logic [TO_W-1:0]   tmr_q;
   logic [EV_NUM-1:0] ev;
   logic hit, unsync, first_elem, step, start, to_hit;
   logic ev_half, ev_frame, ev_block;

   dma_req_pick #(.NREQ(NREQ), .SEL_W(SEL_W)) u_pick (
      .req_in (req_in),
      .sel    (sync_sel),
      .hit    (hit),
      .unsync (unsync)
   );

   assign step  = (st_q == ST_WDONE) && elem_done;
   assign start = (st_q == ST_IDLE) && ch_en;

   dma_pos_cnt #(.CNT_W(CNT_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .step       (step),
      .elem_cnt   (elem_cnt),
      .frame_cnt  (frame_cnt),
      .first_elem (first_elem),
      .last_elem  (last_elem),
      .last_frame (last_frame),
      .ev_half    (ev_half),
      .ev_frame   (ev_frame),
      .ev_block   (ev_block)
   );

   assign to_hit = (st_q == ST_WDONE) && !elem_done && (to_limit != '0)
                   && (tmr_q == to_limit - TO_W'(1));

   always_comb begin
      ev              = '0;
      ev[EV_HALF]     = ev_half;
      ev[EV_FRAME]    = ev_frame;
      ev[EV_BLOCK]    = ev_block;
      ev[EV_LAST_FRM] = (st_q == ST_ISSUE) && first_elem && last_frame;
      ev[EV_DROP]     = hit && ((st_q == ST_ISSUE) || (st_q == ST_WDONE));
      ev[EV_TOUT]     = to_hit;
   end

   always_comb begin
      st_d    = st_q;
      grant_d = grant_q;
      if (!ch_en) begin
         st_d = ST_IDLE;
      end else begin
         unique case (st_q)
            ST_IDLE:  st_d = ST_WREQ;
            ST_WREQ: begin
               if (unsync) begin
                  grant_d = GR_BLOCK;
                  st_d    = ST_ISSUE;
               end else if (hit) begin
                  grant_d = frame_sync ? GR_FRAME : (block_sync ? GR_BLOCK : GR_ELEM);
                  st_d    = ST_ISSUE;
               end
            end
            ST_ISSUE: st_d = ST_WDONE;
            ST_WDONE: begin
               if (elem_done) begin
                  if (last_elem && last_frame) begin
                     if (auto_init && (repeat_en || end_prog)) st_d = ST_WREQ;
                     else if (auto_init)                       st_d = ST_HOLD;
                     else                                      st_d = ST_DONE;
                  end else if (grant_q == GR_BLOCK || (grant_q == GR_FRAME && !last_elem)) begin
                     st_d = ST_ISSUE;
                  end else begin
                     st_d = ST_WREQ;
                  end
               end else if (to_hit) begin
                  st_d = ST_DONE;
               end
            end
            ST_HOLD:  if (end_prog) st_d = ST_WREQ;
            ST_DONE:  st_d = ST_DONE;
            default:  st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         grant_q <= GR_ELEM;
         tmr_q   <= '0;
      end else begin
         st_q    <= st_d;
         grant_q <= grant_d;
         if (st_q == ST_ISSUE)                    tmr_q <= '0;
         else if (st_q == ST_WDONE && !elem_done) tmr_q <= tmr_q + TO_W'(1);
      end
   end

   assign xfer_go = (st_q == ST_ISSUE);
   assign xfer_hi = xfer_go && hi_prio;

   dma_evt_stat #(.NEV(EV_NUM)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (ev),
      .clr    (stat_clr),
      .mask   (irq_mask),
      .status (status),
      .irq    (irq)
   );

   // R2
   go_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_go |=> !xfer_go);

   // R8
   lastfrm_at_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[EV_LAST_FRM] |-> (xfer_go && last_frame));

   // R10
   tout_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[EV_TOUT] && ch_en) |=> (!xfer_go && st_q == ST_DONE));

   // R11
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE) |=> !xfer_go);

   // R9
   drop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[EV_DROP] |-> (st_q != ST_WREQ && st_q != ST_IDLE));

endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        ch_en = 0, frame_sync = 0, block_sync = 0;
   logic [15:0] elem_cnt = 1, frame_cnt = 1;
   logic [4:0]  sync_sel = 0;
   logic        auto_init = 0, repeat_en = 0, end_prog = 0, hi_prio = 0;
   logic [5:0]  irq_mask = 6'h3f;
   logic [7:0]  to_limit = 0;
   logic [30:0] req_in = '0;
   logic        elem_done = 0, stat_clr = 0;
   logic        xfer_go, xfer_hi, last_elem, last_frame, irq;
   logic [5:0]  status;

   dma_chan_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .elem_cnt(elem_cnt),
      .frame_cnt(frame_cnt), .frame_sync(frame_sync), .block_sync(block_sync),
      .sync_sel(sync_sel), .auto_init(auto_init), .repeat_en(repeat_en),
      .end_prog(end_prog), .hi_prio(hi_prio), .irq_mask(irq_mask),
      .to_limit(to_limit), .req_in(req_in), .elem_done(elem_done),
      .stat_clr(stat_clr), .xfer_go(xfer_go), .xfer_hi(xfer_hi),
      .last_elem(last_elem), .last_frame(last_frame), .status(status), .irq(irq)
   );

   int nchk = 0, nfail = 0, nstrobe = 0, lat = 1;
   bit finished = 0;

   task automatic chk(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // behavioural reference model
   int m_st = 0, m_e = 0, m_f = 0, m_gr = 0, m_tmr = 0;
   logic [5:0] m_stat = 0;

   function automatic int eff(input logic [15:0] v);
      return (v == 0) ? 1 : int'(v);
   endfunction

   always @(posedge clk) begin
      int ne, nf, ost, oe, of_;
      logic hit, lastE, lastF;
      logic [5:0] set;
      if (!rst_n) begin
         m_st = 0; m_e = 0; m_f = 0; m_gr = 0; m_tmr = 0; m_stat = 0;
      end else begin
         ne = eff(elem_cnt); nf = eff(frame_cnt);
         hit = (sync_sel != 0) ? req_in[int'(sync_sel) - 1] : 1'b0;
         ost = m_st; oe = m_e; of_ = m_f;
         lastE = (oe == ne - 1); lastF = (of_ == nf - 1);
         set = 0;
         if (hit && (ost == 2 || ost == 3)) set[4] = 1;
         if (ost == 2 && oe == 0 && lastF) set[2] = 1;
         if (ost == 3 && elem_done) begin
            if (ne > 1 && oe + 1 == ne / 2) set[0] = 1;
            if (lastE) begin set[1] = 1; if (lastF) set[3] = 1; end
         end
         if (ost == 3 && !elem_done && to_limit != 0 && m_tmr == int'(to_limit) - 1) set[5] = 1;
         // position
         if (ost == 0 && ch_en) begin m_e = 0; m_f = 0; end
         else if (ost == 3 && elem_done) begin
            if (lastE) begin m_e = 0; m_f = lastF ? 0 : of_ + 1; end
            else m_e = oe + 1;
         end
         // timer
         if (ost == 2) m_tmr = 0;
         else if (ost == 3 && !elem_done) m_tmr = (m_tmr + 1) % 256;
         // control
         if (!ch_en) m_st = 0;
         else case (ost)
            0: m_st = 1;
            1: if (sync_sel == 0) begin m_gr = 2; m_st = 2; end
               else if (hit) begin m_gr = frame_sync ? 1 : (block_sync ? 2 : 0); m_st = 2; end
            2: m_st = 3;
            3: if (elem_done) begin
                  if (lastE && lastF) m_st = !auto_init ? 5 : ((repeat_en || end_prog) ? 1 : 4);
                  else if (m_gr == 2 || (m_gr == 1 && !lastE)) m_st = 2;
                  else m_st = 1;
               end else if (set[5]) m_st = 5;
            4: if (end_prog) m_st = 1;
            default: ;
         endcase
         m_stat = (stat_clr ? 6'h0 : m_stat) | set;
      end
   end

   // per-cycle comparison, away from the edge
   string bit_req [6] = '{"R7 half", "R7 frame", "R8 lastfrm", "R8 block", "R9 drop", "R10 tout"};
   initial begin
      forever begin
         @(posedge clk); #2;
         if (rst_n && !finished) begin
            chk("R2 xfer_go", xfer_go, (m_st == 2));
            chk("R14 xfer_hi", xfer_hi, (m_st == 2) && hi_prio);
            if (m_st == 2) begin
               chk("R6 last_elem", last_elem, (m_e == eff(elem_cnt) - 1));
               chk("R6 last_frame", last_frame, (m_f == eff(frame_cnt) - 1));
            end
            for (int i = 0; i < 6; i++) chk(bit_req[i], status[i], m_stat[i]);
            chk("R13 irq", irq, |(m_stat & irq_mask));
            if (xfer_go) nstrobe++;
         end
      end
   end

   // completion responder
   initial begin
      int pend = 0;
      forever begin
         @(negedge clk);
         if (!ch_en || !rst_n) begin pend = 0; elem_done = 0; end
         else if (xfer_go) begin pend = lat; elem_done = 0; end
         else if (pend > 0) begin pend--; elem_done = (pend == 0); end
         else elem_done = 0;
      end
   end

   task automatic restart();
      @(negedge clk); ch_en = 0; stat_clr = 1;
      @(negedge clk); stat_clr = 0;
      repeat (2) @(negedge clk);
      nstrobe = 0; ch_en = 1;
   endtask

   task automatic pulse(input int k);
      @(negedge clk); req_in[k-1] = 1'b1;
      @(negedge clk); req_in = '0;
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(posedge clk); #2;
      chk("R1 reset go", xfer_go, 0);
      chk("R1 reset status", status, 0);
      chk("R1 reset irq", irq, 0);

      // R2 element mode, timeout off
      elem_cnt = 3; frame_cnt = 2; sync_sel = 5; lat = 3; to_limit = 0;
      restart(); waitc(3);
      for (int i = 0; i < 6; i++) begin pulse(5); waitc(10); end
      chk("R2 strobes per request", nstrobe, 6);
      chk("R7 R8 events", status, 6'h0f);
      chk("R10 disabled timeout", status[5], 0);
      pulse(5); waitc(10);
      chk("R11 stopped", nstrobe, 6);

      // R3 frame mode with drop
      elem_cnt = 4; frame_cnt = 2; frame_sync = 1; sync_sel = 3; lat = 1;
      restart(); waitc(3);
      pulse(3); waitc(3); pulse(3); waitc(20); pulse(3); waitc(20);
      chk("R3 frame strobes", nstrobe, 8);
      chk("R9 drop seen", status, 6'h1f);

      // R4 block mode on top line
      elem_cnt = 2; frame_cnt = 3; frame_sync = 0; block_sync = 1; sync_sel = 31; lat = 2;
      restart(); waitc(3); pulse(31); waitc(40);
      chk("R4 block strobes", nstrobe, 6);
      chk("R4 block status", status, 6'h0f);
      frame_sync = 1;
      restart(); waitc(3); pulse(31); waitc(30);
      chk("R4 precedence strobes", nstrobe, 2);
      chk("R4 precedence status", status, 6'h03);

      // R5 unsynchronized, one-element frames, priority
      frame_sync = 0; block_sync = 0; sync_sel = 0; elem_cnt = 1; frame_cnt = 2; hi_prio = 1;
      restart(); waitc(30);
      chk("R5 free run strobes", nstrobe, 2);
      chk("R7 no half event", status, 6'h0e);
      restart(); waitc(30);
      chk("R11 re-enable restarts", nstrobe, 2);
      hi_prio = 0;

      // R12 repeat and hold
      auto_init = 1; repeat_en = 1; elem_cnt = 2; frame_cnt = 1; lat = 1;
      restart(); waitc(40);
      chk("R12 repeat keeps going", nstrobe > 4, 1);
      repeat_en = 0;
      restart(); waitc(30);
      chk("R12 hold waits", nstrobe, 2);
      end_prog = 1; waitc(20);
      chk("R12 resumes on end_prog", nstrobe > 2, 1);
      end_prog = 0; auto_init = 0;

      // R10 timeout abort
      elem_cnt = 4; frame_cnt = 1; to_limit = 5; lat = 100000;
      restart(); waitc(30);
      chk("R10 one strobe then abort", nstrobe, 1);
      chk("R10 timeout bit", status[5], 1);

      // R13 mask and clear
      @(negedge clk); irq_mask = 6'h00;
      @(posedge clk); #2; chk("R13 masked irq", irq, 0);
      @(negedge clk); irq_mask = 6'h20;
      @(posedge clk); #2; chk("R13 enabled irq", irq, 1);
      @(negedge clk); stat_clr = 1;
      @(negedge clk); stat_clr = 0;
      @(posedge clk); #2;
      chk("R13 clear status", status, 0);
      chk("R13 clear irq", irq, 0);
      irq_mask = 6'h3f;

      // R6 zero counts act as one
      elem_cnt = 0; frame_cnt = 0; to_limit = 0; lat = 1;
      restart(); waitc(20);
      chk("R6 zero counts one strobe", nstrobe, 1);
      chk("R6 zero counts status", status, 6'h0e);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++; nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

endmodule